// File: doc/BRIEF.md
# Serial media-independent port: serializer and deserializer

This block drives and receives one serial MAC-to-PHY link in which all ports share a single 125 MHz reference clock. On the transmit side it takes a byte plus an enable flag and an error flag. It sends them on one wire as a ten-bit group. A one-clock frame marker is raised once in every ten clocks, and the group starts in that same clock.

On the receive side it shifts one wire into a ten-bit group. The group holds a byte, a data-valid bit and a carrier bit. The block presents them together with a one-clock strobe. It also marks a byte as PHY status whenever the data-valid bit of its group is clear.

A mode input selects the 100 Mbps or the 10 Mbps rate. At the lower rate each group is sent ten times in a row, and only one of every ten received repetitions is taken.

Top module: `smii_port`

## Requirements
- R1: `sync` is high for exactly one clock out of every 10, and that clock carries bit 0 of the group.
- R2: A transmit group is sent in this order: `tx_byte` bit 0 first through bit 7 in clocks 0..7 after the marker, then `tx_en` in clock 8, then `tx_er` in clock 9.
- R3: At 100 Mbps `tx_ready` is high in the last clock of every group. The inputs present in that clock are captured and sent as the next group.
- R4: A receive group is taken as byte bits 0..7 in clocks 0..7, the data-valid bit in clock 8 and the carrier bit in clock 9. `rx_byte`, `rx_dv` and `rx_crs` update together, and `rx_valid` pulses for one clock, in the clock after the tenth bit, which is the next marker clock.
- R5: `rx_status` is 1 for a latched group whose data-valid bit is 0, and 0 when that bit is 1.
- R6: With `slow` = 1 a captured group is sent 10 times in a row. `tx_ready` is then high once every 100 clocks, in the last clock of the tenth repetition, and changes on the transmit inputs at any other time have no effect on `tx_line`.
- R7: With `slow` = 1 only the tenth repetition of each 100-clock window is latched, giving one `rx_valid` pulse per window.
- R8: After reset the first clock has `sync` = 1, the transmitted group is all zeros, and `rx_valid`, `rx_byte`, `rx_dv`, `rx_crs` and `rx_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | shared 125 MHz reference clock |
| rst_n | input | 1 | active-low synchronous reset |
| slow | input | 1 | 1 selects 10 Mbps repetition |
| tx_byte | input | 8 | byte to transmit |
| tx_en | input | 1 | transmit enable flag for the group |
| tx_er | input | 1 | transmit error flag for the group |
| tx_ready | output | 1 | transmit inputs are captured at this clock's edge |
| sync | output | 1 | group marker |
| tx_line | output | 1 | serial transmit data |
| rx_line | input | 1 | serial receive data |
| rx_byte | output | 8 | latched received byte |
| rx_dv | output | 1 | latched data-valid bit |
| rx_crs | output | 1 | latched carrier bit |
| rx_status | output | 1 | latched byte is PHY status |
| rx_valid | output | 1 | one-clock strobe for a new latched group |

## Verification
The properties assume that the far end aligns its receive groups to this block's own marker. This holds because the block has no way to find a group boundary by itself. The properties also assume that `slow` is steady across a 100-clock window, so that the repetition count lines up with the window. The bench changes `slow` only between scenarios and always waits for a fresh `tx_ready` before it relies on window alignment. It drives receive bits starting in the marker clock, one bit per clock.

// File: rtl/smii_port.sv
module smii_port #(
  parameter int DATA_W = 8,
  parameter int REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_en,
  input  logic              tx_er,
  output logic              tx_ready,
  output logic              sync,
  output logic              tx_line,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_dv,
  output logic              rx_crs,
  output logic              rx_status,
  output logic              rx_valid
);
  localparam int GRP = DATA_W + 2;
  localparam int PW  = $clog2(GRP);
  localparam int RW  = $clog2(REPEAT);

  logic [PW-1:0]  ph;
  logic [RW-1:0]  rep;
  logic [GRP-1:0] hold, sh;

  wire last_ph  = (ph == PW'(GRP - 1));
  wire last_rep = (rep == RW'(REPEAT - 1));
  wire take     = last_ph && (!slow || last_rep);

  assign sync     = (ph == '0);
  assign tx_ready = take;
  assign tx_line  = hold[ph];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= '0;
      rep <= '0;
    end else if (last_ph) begin
      ph  <= '0;
      rep <= last_rep ? '0 : rep + 1'b1;
    end else begin
      ph  <= ph + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold <= '0;
    else if (take)
      hold <= {tx_er, tx_en, tx_byte};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sh <= '0;
    else
      sh[ph] <= rx_line;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte   <= '0;
      rx_dv     <= 1'b0;
      rx_crs    <= 1'b0;
      rx_status <= 1'b0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= take;
      if (take) begin
        rx_byte   <= sh[DATA_W-1:0];
        rx_dv     <= sh[DATA_W];
        rx_crs    <= rx_line;
        rx_status <= !sh[DATA_W];
      end
    end
  end
endmodule

module smii_port_chk #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic sync,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_dv,
  input logic rx_status
);
  localparam int GRP = DATA_W + 2;
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (sync) begin
      gap  <= 8'd1;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 8'd1;
    end
  end

  p_sync_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && sync) |-> gap == 8'(GRP));

  p_sync_late_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !sync) |-> gap < 8'(GRP));

  p_ready_then_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> sync);

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_valid_on_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> sync);

  p_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_status != rx_dv));
endmodule

bind smii_port smii_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_dv(rx_dv), .rx_status(rx_status)
);

// File: tb/tb_smii_port.sv
module tb_smii_port;
  logic clk = 0, rst_n = 0, slow = 0;
  logic [7:0] tx_byte = 0;
  logic tx_en = 0, tx_er = 0, rx_drv = 0, lb = 0;
  logic tx_ready, sync, tx_line, rx_line;
  logic [7:0] rx_byte;
  logic rx_dv, rx_crs, rx_status, rx_valid;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;
  assign rx_line = lb ? tx_line : rx_drv;

  smii_port dut (
    .clk(clk), .rst_n(rst_n), .slow(slow), .tx_byte(tx_byte), .tx_en(tx_en),
    .tx_er(tx_er), .tx_ready(tx_ready), .sync(sync), .tx_line(tx_line),
    .rx_line(rx_line), .rx_byte(rx_byte), .rx_dv(rx_dv), .rx_crs(rx_crs),
    .rx_status(rx_status), .rx_valid(rx_valid)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ready;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic wait_sync;
    @(negedge clk);
    while (!sync) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8 sync", sync, 1);
    chk("R8 rx_valid", rx_valid, 0);
    chk("R8 rx fields", {rx_byte, rx_dv, rx_crs, rx_status}, 0);
    for (int i = 0; i < 10; i++) begin
      chk("R8 idle tx", tx_line, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_sync_period;
    int highs = 0;
    wait_sync();
    for (int i = 0; i < 30; i++) begin
      if (sync) begin
        highs++;
        chk("R1 sync spacing", i % 10, 0);
      end
      @(negedge clk);
    end
    chk("R1 sync count", highs, 3);
  endtask

  task automatic t_tx(input logic [7:0] b, input logic en, input logic er);
    logic [9:0] exp = {er, en, b};
    wait_ready();
    tx_byte = b; tx_en = en; tx_er = er;
    @(negedge clk);
    tx_byte = ~b;
    chk("R1 sync with bit0", sync, 1);
    for (int i = 0; i < 10; i++) begin
      chk(i < 8 ? "R2 data bit" : "R2 ctrl bit", tx_line, exp[i]);
      chk("R3 ready only last clock", tx_ready, i == 9);
      @(negedge clk);
    end
  endtask

  task automatic drive_group(input logic [9:0] g, inout int nvalid);
    for (int i = 0; i < 10; i++) begin
      rx_drv = g[i];
      @(negedge clk);
      nvalid += rx_valid;
    end
  endtask

  task automatic t_rx(input logic [7:0] b, input logic dv, input logic crs);
    int nv = 0;
    wait_sync();
    drive_group({crs, dv, b}, nv);
    chk("R4 valid pulse", rx_valid, 1);
    chk("R4 rx_byte", rx_byte, b);
    chk("R4 rx_dv", rx_dv, dv);
    chk("R4 rx_crs", rx_crs, crs);
    chk("R5 rx_status", rx_status, !dv);
    @(negedge clk);
    chk("R4 valid one clock", rx_valid, 0);
  endtask

  task automatic t_loop;
    lb = 1;
    wait_ready();
    tx_byte = 8'h3C; tx_en = 1; tx_er = 1;
    for (int i = 0; i < 11; i++) @(negedge clk);
    chk("R4 loop byte", rx_byte, 8'h3C);
    chk("R4 loop dv/crs", {rx_dv, rx_crs}, 2'b11);
    chk("R4 loop valid", rx_valid, 1);
    lb = 0;
  endtask

  task automatic t_slow_tx;
    logic [9:0] exp = {1'b0, 1'b1, 8'hA5};
    slow = 1;
    wait_ready();
    tx_byte = 8'hA5; tx_en = 1; tx_er = 0;
    @(negedge clk);
    tx_byte = 8'h00; tx_en = 0; tx_er = 1;
    for (int k = 0; k < 100; k++) begin
      chk("R6 repeated bit", tx_line, exp[k % 10]);
      chk("R6 ready spacing", tx_ready, k == 99);
      if (k % 10 == 0) chk("R1 slow sync", sync, 1);
      @(negedge clk);
    end
  endtask

  task automatic t_slow_rx;
    int nv = 0;
    for (int r = 0; r < 9; r++) drive_group({1'b0, 1'b0, 8'h5A}, nv);
    drive_group({1'b1, 1'b1, 8'hC3}, nv);
    chk("R7 one valid per window", nv, 1);
    chk("R7 tenth repetition taken", rx_byte, 8'hC3);
    chk("R7 dv/crs", {rx_dv, rx_crs}, 2'b11);
    chk("R5 data not status", rx_status, 0);
    slow = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sync_period();
    t_tx(8'hB4, 1, 0);
    t_tx(8'h01, 0, 1);
    t_rx(8'h96, 1, 1);
    t_rx(8'h2F, 0, 1);
    t_rx(8'hE1, 1, 0);
    t_loop();
    t_slow_tx();
    t_slow_rx();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule